// File: doc/BRIEF.md
# GPIO Port With Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a small 32-bit register bus. The bus uses word addresses. A write takes effect at the clock edge where `bus_we` is high. A read is combinational from `bus_addr` within the same cycle. Software drives the pins through an output data register, which it can write whole or change through an atomic set port and an atomic clear port. A per-pin direction register enables the output driver. Software reads the pins through a two-flop synchronized input view.

Every pin has its own interrupt detector. Three configuration registers pick its trigger: a mode bit (edge or level), a polarity bit, and a both-edges bit. Detected events appear in a raw status word. That word is gated by a per-pin enable, hidden by a per-pin mask to give a masked status word, and OR-reduced onto a single interrupt line. Edge events stay latched until software writes a one to the matching bit of the acknowledge port. Two pull-control words and a bypass word are plain storage that other logic can use. Debounce is not part of this block.

Top module: `gpio_port`

## Requirements
- R1: Word addresses: 0 output data, 1 input view, 2 direction, 3 bypass, 4 set port, 5 clear port, 6 pull enable, 7 pull select, 8 interrupt enable, 9 raw status, 10 masked status, 11 mask, 12 acknowledge, 13 mode, 14 both-edges, 15 polarity. Stored words read back what was last written. Ports 4, 5 and 12 read as zero. Writes to 1, 9 and 10 are ignored.
- R2: Writing to the set port (4) forces each output bit whose written bit is 1 to 1 and leaves the other bits unchanged.
- R3: Writing to the clear port (5) forces each output bit whose written bit is 1 to 0 and leaves the other bits unchanged.
- R4: `pin_out` always equals the output data word. `pin_oe` always equals the direction word, where 1 means the pin drives.
- R5: The input view (1) shows `pin_in` as captured two clock edges earlier.
- R6: With mode bit 1 (level), the raw status bit follows the synchronized pin every cycle. It is high on a high level when polarity is 0 and high on a low level when polarity is 1.
- R7: With mode bit 0 (edge), a rising edge (polarity 0) or a falling edge (polarity 1) of the synchronized pin sets a latched raw status bit. When the both-edges bit is 1, either edge sets it, whatever the polarity. Edges are found one cycle after the synchronized value changes.
- R8: Writing 1 to a bit of the acknowledge port (12) clears that pin's latched edge status. If a new edge on the same pin arrives in the same cycle, the status stays set.
- R9: An interrupt-enable bit of 0 stops the pin from raising raw status.
- R10: Masked status (10) is the raw status with every bit whose mask bit is 1 forced to 0. `irq` is high exactly when any masked status bit is high.
- R11: After reset every register word reads zero, all pins are inputs, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pin drivers |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The collision that matters is an edge reaching a pin's latch in the same cycle that software acknowledges that pin. The bench provokes it on purpose. It toggles a pin, waits for the synchronizer and edge stages, and issues the acknowledge write exactly on the cycle the latch would set. It then expects the status to stay set. A second overlap is a mode, enable or mask write that lands in the same cycle as a pin change. Long stretches of random register writes mixed with random pin toggles produce it. In both cases a behavioural model in the bench predicts every readable word, the pins and `irq`, and the bench compares them with the design every cycle.

// File: rtl/gpio_port_pkg.sv
// Shared word-address map for the GPIO port register bus.
// Assumes: word addressing, 16 words, software decodes these positions.
package gpio_port_pkg;
    localparam int unsigned REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_DOUT  = 4'd0,
        RA_DIN   = 4'd1,
        RA_DIR   = 4'd2,
        RA_BYP   = 4'd3,
        RA_SET   = 4'd4,
        RA_CLR   = 4'd5,
        RA_PEN   = 4'd6,
        RA_PSEL  = 4'd7,
        RA_IEN   = 4'd8,
        RA_RAW   = 4'd9,
        RA_MST   = 4'd10,
        RA_IMASK = 4'd11,
        RA_ACK   = 4'd12,
        RA_MODE  = 4'd13,
        RA_BOTH  = 4'd14,
        RA_POL   = 4'd15
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage input synchronizer. It also keeps one extra delayed copy
// so that edges can be found.
// Assumes: inputs are asynchronous to clk; STAGES >= 2.
module gpio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [W-1:0] chain_q [DEPTH];

    // Shift the pins through the flop chain; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) chain_q[k] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int k = 1; k < DEPTH; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    assign q      = chain_q[STAGES-1];
    assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/gpio_trig_cell.sv
// Trigger detector for one pin: level or edge, with polarity and a
// both-edges option. Edge hits are latched until acknowledged. A new
// edge wins over an acknowledge in the same cycle.
// Assumes: smp and smp_d are synchronized samples one cycle apart.
module gpio_trig_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic smp,
    input  logic smp_d,
    input  logic en,
    input  logic lvl_mode,
    input  logic pol,
    input  logic both,
    input  logic ack,
    output logic raw
);
    logic rise, fall, hit, set_edge, lvl_hit, latch_q;

    assign rise     = smp & ~smp_d;
    assign fall     = ~smp & smp_d;
    assign hit      = both ? (rise | fall) : (pol ? fall : rise);
    assign set_edge = en & ~lvl_mode & hit;
    assign lvl_hit  = pol ? ~smp : smp;

    // Hold the edge event until acknowledged; a new edge takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= 1'b0;
        else if (set_edge) latch_q <= 1'b1;
        else if (ack)      latch_q <= 1'b0;
    end

    assign raw = lvl_mode ? (en & lvl_hit) : latch_q;

    // R8: an edge arriving together with its acknowledge leaves status set.
    a_r8_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !lvl_mode && both && ack && (smp != smp_d)) |=> latch_q);

    // R9: a disabled level pin never shows raw status.
    a_r9_disabled_level: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_mode && !en) |-> !raw);

    // R7: with the mode unchanged and no acknowledge, latched edge status persists.
    a_r7_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_mode && latch_q && !ack) |=> latch_q);
endmodule

// File: rtl/gpio_irq_merge.sv
// Applies the per-pin mask to raw status and OR-reduces the result
// onto one request line.
// Assumes: mask bit 1 hides the pin.
module gpio_irq_merge #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    output logic [W-1:0] masked,
    output logic         req
);
    assign masked = raw & ~mask;
    assign req    = |masked;
endmodule

// File: rtl/gpio_port.sv
// GPIO port top: register bank, bus read mux, synchronizer, per-pin
// trigger detectors and interrupt merge.
// Assumes: one bus access per cycle; writes commit at the clock edge and
// reads are combinational from bus_addr.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PIN_N       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [PIN_N-1:0]  bus_wdata,
    output logic [PIN_N-1:0]  bus_rdata,
    input  logic [PIN_N-1:0]  pin_in,
    output logic [PIN_N-1:0]  pin_out,
    output logic [PIN_N-1:0]  pin_oe,
    output logic              irq
);
    localparam logic [PIN_N-1:0] ALL_ONES = {PIN_N{1'b1}};

    reg_addr_e        ra;
    logic [PIN_N-1:0] dout_q, dir_q, byp_q, pen_q, psel_q;
    logic [PIN_N-1:0] ien_q, imask_q, mode_q, both_q, pol_q;
    logic [PIN_N-1:0] smp, smp_d, raw, masked, ack_v;

    assign ra = reg_addr_e'(bus_addr);

    // Commit bus writes to the stored words and the output set/clear ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0; dir_q <= '0; byp_q <= '0; pen_q <= '0; psel_q <= '0;
            ien_q <= '0; imask_q <= '0; mode_q <= '0; both_q <= '0; pol_q <= '0;
        end else if (bus_we) begin
            case (ra)
                RA_DOUT:  dout_q  <= bus_wdata;
                RA_SET:   dout_q  <= dout_q | bus_wdata;
                RA_CLR:   dout_q  <= dout_q & ~bus_wdata;
                RA_DIR:   dir_q   <= bus_wdata;
                RA_BYP:   byp_q   <= bus_wdata;
                RA_PEN:   pen_q   <= bus_wdata;
                RA_PSEL:  psel_q  <= bus_wdata;
                RA_IEN:   ien_q   <= bus_wdata;
                RA_IMASK: imask_q <= bus_wdata;
                RA_MODE:  mode_q  <= bus_wdata;
                RA_BOTH:  both_q  <= bus_wdata;
                RA_POL:   pol_q   <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Acknowledge pulses exist only during a write to the acknowledge port.
    assign ack_v = (bus_we && ra == RA_ACK) ? bus_wdata : '0;

    gpio_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp), .q_prev(smp_d)
    );

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        gpio_trig_cell u_cell (
            .clk(clk), .rst_n(rst_n), .smp(smp[i]), .smp_d(smp_d[i]),
            .en(ien_q[i]), .lvl_mode(mode_q[i]), .pol(pol_q[i]),
            .both(both_q[i]), .ack(ack_v[i]), .raw(raw[i])
        );
    end

    gpio_irq_merge #(.W(PIN_N)) u_merge (
        .raw(raw), .mask(imask_q), .masked(masked), .req(irq)
    );

    // Select the word addressed on the bus; write-only ports read zero.
    always_comb begin
        case (ra)
            RA_DOUT:  bus_rdata = dout_q;
            RA_DIN:   bus_rdata = smp;
            RA_DIR:   bus_rdata = dir_q;
            RA_BYP:   bus_rdata = byp_q;
            RA_PEN:   bus_rdata = pen_q;
            RA_PSEL:  bus_rdata = psel_q;
            RA_IEN:   bus_rdata = ien_q;
            RA_RAW:   bus_rdata = raw;
            RA_MST:   bus_rdata = masked;
            RA_IMASK: bus_rdata = imask_q;
            RA_MODE:  bus_rdata = mode_q;
            RA_BOTH:  bus_rdata = both_q;
            RA_POL:   bus_rdata = pol_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;

    // R2: bits written to the set port are high afterwards.
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ra == RA_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: bits written to the clear port are low afterwards.
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ra == RA_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

    // R10: a fully masked port never requests.
    a_r10_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q == ALL_ONES) |-> !irq);

    // R11: a reset cycle leaves outputs cleared and all pins as inputs.
    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && !irq));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rdata, pin_out, pin_oe;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model state
    logic [31:0] m_dout, m_dir, m_byp, m_pen, m_psel, m_ien, m_mask, m_mode, m_both, m_pol;
    logic [31:0] m_y1, m_s, m_p, m_lat;

    function automatic logic [31:0] m_raw();
        logic [31:0] r;
        for (int i = 0; i < 32; i++)
            r[i] = m_mode[i] ? (m_ien[i] & (m_pol[i] ? ~m_s[i] : m_s[i])) : m_lat[i];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_dout;   4'd1: return m_s;      4'd2: return m_dir;
            4'd3: return m_byp;    4'd6: return m_pen;    4'd7: return m_psel;
            4'd8: return m_ien;    4'd9: return m_raw();  4'd10: return m_raw() & ~m_mask;
            4'd11: return m_mask;  4'd13: return m_mode;  4'd14: return m_both;
            4'd15: return m_pol;   default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R1 R2 R3 readback";
            4'd1: return "R5 input view";
            4'd9: return "R6 R7 R8 R9 raw status";
            4'd10: return "R10 masked status";
            default: return "R1 register word";
        endcase
    endfunction

    // Model update at each clock edge from the inputs the bench holds.
    always @(posedge clk) begin
        logic [31:0] nlat, ackv;
        logic r, f, h;
        if (!rst_n) begin
            m_dout = 0; m_dir = 0; m_byp = 0; m_pen = 0; m_psel = 0; m_ien = 0;
            m_mask = 0; m_mode = 0; m_both = 0; m_pol = 0;
            m_y1 = 0; m_s = 0; m_p = 0; m_lat = 0;
        end else begin
            ackv = (we && addr == 4'd12) ? wdata : 32'h0;
            for (int i = 0; i < 32; i++) begin
                r = m_s[i] & ~m_p[i];
                f = ~m_s[i] & m_p[i];
                h = m_both[i] ? (r | f) : (m_pol[i] ? f : r);
                if (m_ien[i] && !m_mode[i] && h) nlat[i] = 1'b1;
                else if (ackv[i])                nlat[i] = 1'b0;
                else                             nlat[i] = m_lat[i];
            end
            m_lat = nlat;
            m_p = m_s; m_s = m_y1; m_y1 = pin_in;
            if (we) begin
                case (addr)
                    4'd0: m_dout = wdata;
                    4'd4: m_dout = m_dout | wdata;
                    4'd5: m_dout = m_dout & ~wdata;
                    4'd2: m_dir = wdata;   4'd3: m_byp = wdata;
                    4'd6: m_pen = wdata;   4'd7: m_psel = wdata;
                    4'd8: m_ien = wdata;   4'd11: m_mask = wdata;
                    4'd13: m_mode = wdata; 4'd14: m_both = wdata;
                    4'd15: m_pol = wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(tag_of(addr), rdata, m_read(addr));
        chk("R4 pin_out", pin_out, m_dout);
        chk("R4 pin_oe", pin_oe, m_dir);
        chk("R10 irq", {31'b0, irq}, {31'b0, |(m_raw() & ~m_mask)});
    endtask

    // One bus cycle: compare on the falling edge, then drive the next inputs.
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] p);
        @(negedge clk);
        check_all();
        we = w; addr = a; wdata = d; pin_in = p;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, pin_in);
    endtask

    task automatic rd(input logic [3:0] a, input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, a, 32'h0, pin_in);
    endtask

    task automatic pin(input logic [31:0] p, input logic [3:0] a);
        cyc(1'b0, a, 32'h0, p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: every word reads zero right after reset
        for (int a = 0; a < 16; a++) rd(4'(a), 1);
        @(negedge clk);
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
        chk("R11 oe after reset", pin_oe, 32'h0);

        // R1 R2 R3 R4: output data, set and clear ports
        wr(4'd0, 32'hA5A5_0000);
        wr(4'd4, 32'h0000_00FF);
        wr(4'd5, 32'hA000_000F);
        wr(4'd2, 32'hFFFF_0000);
        rd(4'd0, 1);
        rd(4'd4, 1);
        wr(4'd1, 32'hFFFF_FFFF);  // R1: input view is read-only
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd1, 1);
        rd(4'd9, 1);
        for (int a = 0; a < 16; a++) wr(4'(a), 32'h1234_5678 ^ (a * 32'h0101_0101));
        for (int a = 0; a < 16; a++) rd(4'(a), 1);
        wr(4'd8, 0); wr(4'd13, 0); wr(4'd14, 0); wr(4'd15, 0); wr(4'd11, 0);
        wr(4'd12, 32'hFFFF_FFFF);

        // R5: input view latency
        pin(32'h0F0F_0000, 4'd1);
        rd(4'd1, 3);

        // R6: level pins 0 (high) and 1 (low)
        pin(32'h0, 4'd9);
        wr(4'd13, 32'h3); wr(4'd15, 32'h2); wr(4'd8, 32'h3);
        rd(4'd9, 3);
        pin(32'h3, 4'd9);
        rd(4'd9, 3);

        // R7: rising on pin 4, falling on pin 5, both on pin 6
        wr(4'd13, 0); wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd15, 32'h20); wr(4'd14, 32'h40); wr(4'd8, 32'h70);
        pin(32'h70, 4'd9); rd(4'd9, 3);
        pin(32'h00, 4'd9); rd(4'd9, 3);
        wr(4'd12, 32'h70); rd(4'd9, 2);

        // R8: acknowledge lands in the cycle the new edge latches
        pin(32'h40, 4'd9);
        rd(4'd9, 1);
        wr(4'd12, 32'h40);
        rd(4'd9, 1);
        @(negedge clk);
        chk("R8 edge wins over ack", rdata & 32'h40, 32'h40);
        wr(4'd12, 32'h40); rd(4'd9, 2);

        // R9: disabled pins raise nothing
        wr(4'd8, 32'h0);
        pin(32'h0, 4'd9); rd(4'd9, 4);
        pin(32'h70, 4'd9); rd(4'd9, 4);

        // R10: mask hides status and irq
        wr(4'd8, 32'h70); pin(32'h0, 4'd10); rd(4'd10, 4);
        wr(4'd11, 32'h70); rd(4'd10, 2);
        wr(4'd11, 32'h20); rd(4'd10, 2);

        // Random mix of writes, reads and pin changes
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] rv = $urandom;
            logic [31:0] np = pin_in;
            if (rv[3:0] < 4'd5) np = pin_in ^ ($urandom & $urandom);
            cyc(rv[4] & rv[5], 4'($urandom), $urandom, np);
        end
        rd(4'd0, 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule